// File: doc/BRIEF.md
# Multi-Slot Delayed Branch Resolver

This block settles conditional branches that arrive together in one instruction bundle, one per flow slot. Each slot branch names a sense (taken on a false predicate or on a true predicate), a predicate select, a target offset and a delay. The block holds every issued branch until its delay runs out. It then reads the chosen bit of the live predicate vector in that cycle and decides whether the branch is taken.

When several branches are taken in the same cycle, one winner is chosen. The earliest issue cycle wins first, and within one issue cycle the lowest slot wins. The block then emits a one-cycle redirect. The target is the offset added to the entry address of the current block, and the block records that target as its new entry address. A redirect cancels every branch still waiting from the old block.

Top module: `branch_resolver`

## Requirements
- R1: During and just after reset, `redir_valid` is 0 and `block_entry` equals the parameter `RESET_VEC`. Reset also leaves no branch pending.
- R2: A branch with `iss_on_true` bit 0 is taken when its selected predicate is 0. A branch with `iss_on_true` bit 1 is taken when its selected predicate is 1.
- R3: A branch issued in cycle t with delay d reads its predicate in cycle t+1+d only, and a taken result shows as `redir_valid` in cycle t+2+d. The predicate value in any other cycle has no effect.
- R4: If several slots of the same issue cycle are taken in the same cycle, the lowest-numbered slot supplies the target.
- R5: If branches from different issue cycles are taken in the same cycle, the branch issued earlier wins over any slot of a later issue.
- R6: The target is `block_entry` plus the offset, modulo 2^ADDR_W. In the cycle `redir_valid` is high, `block_entry` already equals `redir_target`.
- R7: A redirect cancels all pending branches, including those issued in the cycle the winning predicate was read. None of them can cause a later redirect.
- R8: `redir_valid` is never high in two consecutive cycles.
- R9: A branch that is not taken causes no redirect and leaves `block_entry` unchanged.
- R10: Slot k reads bit `iss_pred_sel[k*SEL_W +: SEL_W]` of `pred_vec`. No other predicate bit affects that branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_valid | input | NUM_SLOTS | Slot k carries a branch this cycle |
| iss_on_true | input | NUM_SLOTS | Sense per slot: 1 = taken on true predicate, 0 = taken on false predicate |
| iss_pred_sel | input | NUM_SLOTS*SEL_W | Predicate bit index per slot |
| iss_offset | input | NUM_SLOTS*ADDR_W | Target offset per slot, relative to the block entry |
| iss_delay | input | NUM_SLOTS*DELAY_W | Extra cycles before the predicate is read |
| pred_vec | input | PRED_N | Live predicate bits |
| redir_valid | output | 1 | One-cycle redirect pulse |
| redir_target | output | ADDR_W | Absolute redirect address |
| block_entry | output | ADDR_W | Entry address of the current block |

## Verification
The assertions assume that a branch's delay fits in `DELAY_W` bits, so every entry has matured by the last pipeline stage. They also assume `PRED_N` is a power of two, so every select value names a real predicate bit. The stimulus draws delays, selects and offsets uniformly within those field widths. Directed cases arrange coinciding maturities across issue cycles, wrapping targets, and a predicate that flips away from its sampling cycle.

// File: rtl/brs_pkg.sv
// Package: shared types for the branch resolver.
// Assumes nothing beyond a single sense bit per branch.
package brs_pkg;

    // Branch sense: which predicate value makes the branch taken.
    typedef enum logic {
        SENSE_FALSE = 1'b0,
        SENSE_TRUE  = 1'b1
    } br_sense_e;

    // Decide whether a branch with sense s is taken given predicate p.
    function automatic logic resolves_taken(input br_sense_e s, input logic p);
        return (s == SENSE_TRUE) ? p : ~p;
    endfunction

endpackage

// File: rtl/brs_pending.sv
// Module: brs_pending
// Holds issued branches in a shift chain with one stage per cycle of age.
// Stage 0 holds branches issued in the previous cycle. Each entry keeps a
// down-counter, and an entry whose counter reads zero is mature: its
// predicate is read in this cycle and it leaves the chain.
// Assumes the delay fits in DELAY_W bits (NSTG = 2**DELAY_W stages).
module brs_pending
    import brs_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 32,
    parameter int DELAY_W   = 3,
    parameter int PRED_N    = 8,
    parameter int SEL_W     = 3,
    parameter int NSTG      = 8
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          flush,
    input  logic [NUM_SLOTS-1:0]                          iss_valid,
    input  logic [NUM_SLOTS-1:0]                          iss_on_true,
    input  logic [NUM_SLOTS-1:0][SEL_W-1:0]               iss_sel,
    input  logic [NUM_SLOTS-1:0][ADDR_W-1:0]              iss_off,
    input  logic [NUM_SLOTS-1:0][DELAY_W-1:0]             iss_delay,
    input  logic [PRED_N-1:0]                             pred_vec,
    output logic [NSTG-1:0][NUM_SLOTS-1:0]                taken,
    output logic [NSTG-1:0][NUM_SLOTS-1:0][ADDR_W-1:0]    off_q,
    output logic                                          busy
);

    logic      [NSTG-1:0][NUM_SLOTS-1:0]              v_q;
    logic      [NSTG-1:0][NUM_SLOTS-1:0][DELAY_W-1:0] cnt_q;
    logic      [NSTG-1:0][NUM_SLOTS-1:0][SEL_W-1:0]   sel_q;
    br_sense_e [NSTG-1:0][NUM_SLOTS-1:0]              sense_q;
    logic      [NSTG-1:0][NUM_SLOTS-1:0]              mature;

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        logic      [NUM_SLOTS-1:0]              st_v;
        logic      [NUM_SLOTS-1:0][DELAY_W-1:0] st_cnt;
        logic      [NUM_SLOTS-1:0][SEL_W-1:0]   st_sel;
        logic      [NUM_SLOTS-1:0][ADDR_W-1:0]  st_off;
        br_sense_e [NUM_SLOTS-1:0]              st_sense;

        if (s == 0) begin : g_head
            // Capture newly issued branches; a flush or reset drops them.
            always_ff @(posedge clk) begin
                if (!rst_n || flush) begin
                    st_v <= '0;
                end else begin
                    st_v <= iss_valid;
                end
                for (int k = 0; k < NUM_SLOTS; k++) begin
                    st_cnt[k]   <= iss_delay[k];
                    st_sel[k]   <= iss_sel[k];
                    st_off[k]   <= iss_off[k];
                    st_sense[k] <= br_sense_e'(iss_on_true[k]);
                end
            end
        end else begin : g_body
            // Age entries by one stage; mature ones stop here.
            always_ff @(posedge clk) begin
                for (int k = 0; k < NUM_SLOTS; k++) begin
                    if (!rst_n || flush) begin
                        st_v[k] <= 1'b0;
                    end else begin
                        st_v[k] <= v_q[s-1][k] && !mature[s-1][k];
                    end
                    st_cnt[k]   <= cnt_q[s-1][k] - DELAY_W'(1);
                    st_sel[k]   <= sel_q[s-1][k];
                    st_off[k]   <= off_q[s-1][k];
                    st_sense[k] <= sense_q[s-1][k];
                end
            end
        end

        assign v_q[s]     = st_v;
        assign cnt_q[s]   = st_cnt;
        assign sel_q[s]   = st_sel;
        assign off_q[s]   = st_off;
        assign sense_q[s] = st_sense;

        // Flag mature entries and read their predicate in this cycle.
        always_comb begin
            for (int k = 0; k < NUM_SLOTS; k++) begin
                mature[s][k] = st_v[k] && (st_cnt[k] == '0);
                taken[s][k]  = mature[s][k] &&
                               resolves_taken(st_sense[k], pred_vec[st_sel[k]]);
            end
        end
    end

    assign busy = |v_q;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_drain
        // R3
        last_stage_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
            v_q[NSTG-1][k] |-> (cnt_q[NSTG-1][k] == '0));
    end

endmodule

// File: rtl/brs_pick.sv
// Module: brs_pick
// Chooses one winner among taken entries: the oldest stage first, then the
// lowest slot within that stage. Outputs a one-hot grant and the offset.
// Assumes taken bits come only from mature entries.
module brs_pick #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 32,
    parameter int NSTG      = 8
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [NSTG-1:0][NUM_SLOTS-1:0]              taken,
    input  logic [NSTG-1:0][NUM_SLOTS-1:0][ADDR_W-1:0]  off,
    output logic                                        any,
    output logic [ADDR_W-1:0]                           win_off
);

    logic [NSTG-1:0][NUM_SLOTS-1:0] win_oh;

    // Scan young to old, high slot to low; the last hit is the winner.
    always_comb begin
        win_oh  = '0;
        win_off = '0;
        for (int s = 0; s < NSTG; s++) begin
            for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
                if (taken[s][k]) begin
                    win_oh       = '0;
                    win_oh[s][k] = 1'b1;
                    win_off      = off[s][k];
                end
            end
        end
    end

    assign any = |taken;

    // R4
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> $onehot(win_oh));

    // R5
    grant_is_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_oh & ~taken) == '0);

endmodule

// File: rtl/branch_resolver.sv
// Module: branch_resolver (top)
// Resolves delayed conditional branches from several flow slots and drives
// a registered one-cycle redirect whose target is relative to the current
// block entry. A redirect moves the block entry and cancels all pending work.
// Assumes NUM_SLOTS in 1..4 and PRED_N a power of two.
module branch_resolver #(
    parameter int          NUM_SLOTS = 4,
    parameter int          ADDR_W    = 32,
    parameter int          DELAY_W   = 3,
    parameter int          PRED_N    = 8,
    parameter logic [31:0] RESET_VEC = 32'h0000_1000,
    localparam int         SEL_W     = (PRED_N > 1) ? $clog2(PRED_N) : 1,
    localparam int         NSTG      = 1 << DELAY_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SLOTS-1:0]           iss_valid,
    input  logic [NUM_SLOTS-1:0]           iss_on_true,
    input  logic [NUM_SLOTS*SEL_W-1:0]     iss_pred_sel,
    input  logic [NUM_SLOTS*ADDR_W-1:0]    iss_offset,
    input  logic [NUM_SLOTS*DELAY_W-1:0]   iss_delay,
    input  logic [PRED_N-1:0]              pred_vec,
    output logic                           redir_valid,
    output logic [ADDR_W-1:0]              redir_target,
    output logic [ADDR_W-1:0]              block_entry
);

    logic [NUM_SLOTS-1:0][SEL_W-1:0]            sel_w;
    logic [NUM_SLOTS-1:0][ADDR_W-1:0]           off_w;
    logic [NUM_SLOTS-1:0][DELAY_W-1:0]          dly_w;
    logic [NSTG-1:0][NUM_SLOTS-1:0]             taken;
    logic [NSTG-1:0][NUM_SLOTS-1:0][ADDR_W-1:0] pend_off;
    logic                                       pend_busy;
    logic                                       win_any;
    logic [ADDR_W-1:0]                          win_off;
    logic [ADDR_W-1:0]                          next_target;

    assign sel_w = iss_pred_sel;
    assign off_w = iss_offset;
    assign dly_w = iss_delay;

    brs_pending #(
        .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .DELAY_W(DELAY_W),
        .PRED_N(PRED_N), .SEL_W(SEL_W), .NSTG(NSTG)
    ) u_pending (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (win_any),
        .iss_valid  (iss_valid),
        .iss_on_true(iss_on_true),
        .iss_sel    (sel_w),
        .iss_off    (off_w),
        .iss_delay  (dly_w),
        .pred_vec   (pred_vec),
        .taken      (taken),
        .off_q      (pend_off),
        .busy       (pend_busy)
    );

    brs_pick #(
        .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .NSTG(NSTG)
    ) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .taken  (taken),
        .off    (pend_off),
        .any    (win_any),
        .win_off(win_off)
    );

    // Entry-relative target, wrapping at the address width.
    assign next_target = block_entry + win_off;

    // Register the redirect pulse and move the block entry on a win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid  <= 1'b0;
            redir_target <= '0;
            block_entry  <= RESET_VEC[ADDR_W-1:0];
        end else begin
            redir_valid <= win_any;
            if (win_any) begin
                redir_target <= next_target;
                block_entry  <= next_target;
            end
        end
    end

    // R8
    redir_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !redir_valid);

    // R6
    entry_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (block_entry == redir_target));

    // R7
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_any |=> !pend_busy);

    // R9
    entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !redir_valid |-> $stable(block_entry));

endmodule

// File: tb/test_branch_resolver.sv
`timescale 1ns/1ps
module test_branch_resolver;

    localparam int          NS = 4;
    localparam int          AW = 32;
    localparam int          DW = 3;
    localparam int          PN = 8;
    localparam int          SW = 3;
    localparam logic [31:0] RV = 32'h0000_1000;
    localparam int          MP = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NS-1:0]  iss_valid = '0;
    logic [NS-1:0]  iss_on_true = '0;
    logic [NS*SW-1:0] iss_pred_sel = '0;
    logic [NS*AW-1:0] iss_offset = '0;
    logic [NS*DW-1:0] iss_delay = '0;
    logic [PN-1:0]  pred_vec = '0;
    logic           redir_valid;
    logic [AW-1:0]  redir_target;
    logic [AW-1:0]  block_entry;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state
    bit          m_v     [MP];
    int          m_due   [MP];
    int          m_age   [MP];
    int          m_slot  [MP];
    bit          m_sense [MP];
    int          m_sel   [MP];
    logic [31:0] m_off   [MP];
    logic [31:0] m_entry;

    always #2 clk = ~clk;

    branch_resolver #(.NUM_SLOTS(NS), .ADDR_W(AW), .DELAY_W(DW), .PRED_N(PN), .RESET_VEC(RV))
    i_branch_resolver (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_on_true(iss_on_true),
        .iss_pred_sel(iss_pred_sel), .iss_offset(iss_offset), .iss_delay(iss_delay),
        .pred_vec(pred_vec), .redir_valid(redir_valid), .redir_target(redir_target),
        .block_entry(block_entry)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic issue(input int k, input bit on_t, input int sel, input logic [31:0] off, input int d);
        iss_valid[k] = 1'b1;
        iss_on_true[k] = on_t;
        iss_pred_sel[k*SW +: SW] = sel[SW-1:0];
        iss_offset[k*AW +: AW] = off;
        iss_delay[k*DW +: DW] = d[DW-1:0];
    endtask

    // Run one cycle: predict from requirements, clock, compare.
    task automatic step(input string tag);
        int best;
        bit ev;
        logic [31:0] et;
        best = -1;
        ev = 0;
        et = '0;
        for (int p = 0; p < MP; p++) begin
            if (m_v[p] && m_due[p] == cyc) begin
                if (pred_vec[m_sel[p]] == m_sense[p]) begin
                    if (best < 0 || m_age[p] < m_age[best] ||
                        (m_age[p] == m_age[best] && m_slot[p] < m_slot[best]))
                        best = p;
                end
                m_v[p] = 0;
            end
        end
        if (best >= 0) begin
            ev = 1;
            et = m_entry + m_off[best];
            m_entry = et;
            for (int p = 0; p < MP; p++) m_v[p] = 0;
        end else begin
            for (int k = 0; k < NS; k++) begin
                if (iss_valid[k]) begin
                    for (int p = 0; p < MP; p++) begin
                        if (!m_v[p]) begin
                            m_v[p] = 1;
                            m_due[p] = cyc + 1 + int'(iss_delay[k*DW +: DW]);
                            m_age[p] = cyc;
                            m_slot[p] = k;
                            m_sense[p] = iss_on_true[k];
                            m_sel[p] = int'(iss_pred_sel[k*SW +: SW]);
                            m_off[p] = iss_offset[k*AW +: AW];
                            break;
                        end
                    end
                end
            end
        end
        @(posedge clk);
        #1;
        check(redir_valid == ev, tag, {31'd0, redir_valid}, {31'd0, ev});
        if (ev) check(redir_target == et, tag, redir_target, et);
        check(block_entry == m_entry, tag, block_entry, m_entry);
        cyc++;
        iss_valid = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int p = 0; p < MP; p++) m_v[p] = 0;
        m_entry = RV;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(redir_valid == 1'b0, "R1", {31'd0, redir_valid}, 32'd0);
        check(block_entry == RV, "R1", block_entry, RV);
        rst_n = 1'b1;
        step("R1");

        // R2 on-false taken with predicate 0
        issue(0, 0, 0, 32'h40, 0); pred_vec = 8'h00; step("R2");
        step("R2");
        step("R8");
        // R2 on-true taken with predicate 1
        issue(1, 1, 2, 32'h100, 0); step("R2");
        pred_vec = 8'h04; step("R2");
        pred_vec = 8'h00; step("R8");
        // R9 on-false with predicate 1: no redirect
        issue(0, 0, 1, 32'h20, 0); step("R9");
        pred_vec = 8'h02; step("R9");
        step("R9");

        // R3 delay 3: predicate only matters in the maturity cycle
        pred_vec = 8'h08; issue(2, 1, 3, 32'h80, 3); step("R3");
        pred_vec = 8'h00; step("R3"); step("R3"); step("R3");
        pred_vec = 8'h08; step("R3");
        pred_vec = 8'h00; step("R8");
        // R3 negative: true everywhere except maturity
        pred_vec = 8'h08; issue(2, 1, 3, 32'h90, 2); step("R3");
        step("R3"); step("R3");
        pred_vec = 8'h00; step("R3");
        pred_vec = 8'h08; step("R3"); step("R3");

        // R4 lowest slot wins in one issue cycle
        pred_vec = 8'h01;
        issue(3, 1, 0, 32'h30, 0); issue(1, 1, 0, 32'h10, 0); issue(2, 0, 0, 32'h50, 0);
        step("R4");
        step("R4");
        pred_vec = 8'h00; step("R8");

        // R5 earlier issue wins over a lower slot issued later
        issue(3, 1, 0, 32'h200, 2); step("R5");
        step("R5");
        issue(0, 1, 0, 32'h300, 0); step("R5");
        pred_vec = 8'h01; step("R5");
        pred_vec = 8'h00; step("R8");

        // R6 wrap-around target
        issue(0, 1, 7, 32'hFFFF_FFF0, 0); step("R6");
        pred_vec = 8'h80; step("R6");
        pred_vec = 8'h00; step("R6");

        // R10 predicate select
        issue(2, 1, 5, 32'h44, 0); step("R10");
        pred_vec = 8'hDF; step("R10");
        issue(2, 1, 5, 32'h48, 0); step("R10");
        pred_vec = 8'h20; step("R10");
        pred_vec = 8'h00; step("R10");

        // R7 cancel pending on redirect, including same-cycle issues
        issue(1, 1, 0, 32'h500, 5); step("R7");
        issue(0, 1, 1, 32'h600, 0); step("R7");
        pred_vec = 8'h02; issue(3, 1, 0, 32'h700, 1); step("R7");
        pred_vec = 8'h01;
        for (int i = 0; i < 8; i++) step("R7");

        // mixed random traffic
        for (int i = 0; i < 4000; i++) begin
            pred_vec = PN'($urandom);
            for (int k = 0; k < NS; k++) begin
                if ($urandom_range(9, 0) < 3)
                    issue(k, 1'($urandom), int'($urandom_range(PN-1, 0)), $urandom,
                          int'($urandom_range((1 << DW) - 1, 0)));
            end
            step("R3");
        end
        summary();
    end

    initial begin
        void'($urandom(32'h1357_2468));
    end

endmodule